// File: doc/BRIEF.md
# Ripple-Chained Integer Arithmetic Logic Unit

This block is a purely combinational integer arithmetic logic unit of parameterised width, 32 bits by default. It is built as a ripple chain of one-bit cells. Each cell has an AND gate, an OR gate, a full adder, an optional inverter on each operand, and a four-way result selector. A single 4-bit operation code drives the whole chain. Its top bit inverts operand A, the next bit negates operand B, and the low two bits pick which cell output reaches the result.

The negate bit inverts B in every cell and also supplies the carry into cell 0. That one control therefore turns the adder into a subtractor. NOR is the AND path applied to both inverted operands. For the signed less-than comparison, every cell except cell 0 outputs a constant 0. Cell 0 outputs a set bit taken from the top of the subtraction, corrected for signed overflow. Alongside the result the block reports a carry-out, a signed overflow flag and a zero flag, so a datapath can branch on equality and detect arithmetic wrap.

Top module: `bitslice_alu`

## Requirements
- R1: Operation code 4'b0000 gives the bitwise AND of A and B.
- R2: Operation code 4'b0001 gives the bitwise OR of A and B.
- R3: Operation code 4'b0010 gives A plus B, modulo 2^WIDTH.
- R4: Operation code 4'b0110 gives A minus B, modulo 2^WIDTH. This is formed as A plus inverted B plus a carry-in of 1.
- R5: Operation code 4'b0111 gives 1 in bit 0 when A is less than B as signed two's complement numbers, and 0 otherwise. All other result bits are 0, and the answer is correct even when A minus B overflows.
- R6: Operation code 4'b1100 gives the bitwise NOR of A and B.
- R7: For add and subtract, the overflow flag is 1 exactly when the signed result does not fit in WIDTH bits. This equals the carry into the top cell XOR the carry out of it.
- R8: For AND, OR, NOR and less-than, the overflow flag is 0.
- R9: For add and subtract, the carry flag is the carry leaving the top cell; for subtract, 1 means no unsigned borrow. For all other operations the carry flag is 0.
- R10: The zero flag is 1 exactly when every result bit is 0.
- R11: Adding two operands of opposite sign never raises overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| op_i | input | 4 | Operation code: bit 3 inverts A, bit 2 negates B, bits 1:0 select the result |
| result_o | output | WIDTH | Operation result |
| carry_o | output | 1 | Carry out of the top cell (add and subtract only) |
| overflow_o | output | 1 | Signed overflow (add and subtract only) |
| zero_o | output | 1 | All result bits are zero |

## Verification
The block holds no state, so any fault in a cell's inverter, carry or selector shows on the same vector that excites it. The effect is a wrong result bit, a misplaced carry, or a false overflow. The set bit loops from the top cell back to cell 0. A fault in it therefore appears only under the less-than code, and mostly when A minus B overflows, so those operand pairs are driven on purpose. Carry and overflow flags that leak into logic operations show up as nonzero flags under AND, OR and NOR.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;
   localparam int unsigned OPC_W = 4;

   typedef enum logic [1:0] {
      SEL_AND  = 2'b00,
      SEL_OR   = 2'b01,
      SEL_SUM  = 2'b10,
      SEL_LESS = 2'b11
   } sel_e;

   typedef struct packed {
      logic inv_a;
      logic neg_b;
      sel_e sel;
   } opcode_t;

   localparam logic [OPC_W-1:0] OPC_AND = 4'b0000;
   localparam logic [OPC_W-1:0] OPC_OR  = 4'b0001;
   localparam logic [OPC_W-1:0] OPC_ADD = 4'b0010;
   localparam logic [OPC_W-1:0] OPC_SUB = 4'b0110;
   localparam logic [OPC_W-1:0] OPC_SLT = 4'b0111;
   localparam logic [OPC_W-1:0] OPC_NOR = 4'b1100;
endpackage

// File: rtl/bsalu_cell.sv
module bsalu_cell
   import bsalu_pkg::*;
(
   input  logic a_i,
   input  logic b_i,
   input  logic inv_a_i,
   input  logic neg_b_i,
   input  sel_e sel_i,
   input  logic carry_i,
   input  logic less_i,
   output logic res_o,
   output logic carry_o,
   output logic sum_o,
   output logic a_eff_o,
   output logic b_eff_o
);
   logic a_x, b_x, and_x, or_x, sum_x, cy_x;

   assign a_x   = inv_a_i ? ~a_i : a_i;
   assign b_x   = neg_b_i ? ~b_i : b_i;
   assign and_x = a_x & b_x;
   assign or_x  = a_x | b_x;
   assign sum_x = a_x ^ b_x ^ carry_i;
   assign cy_x  = (a_x & b_x) | (a_x & carry_i) | (b_x & carry_i);

   always_comb begin
      unique case (sel_i)
         SEL_AND:  res_o = and_x;
         SEL_OR:   res_o = or_x;
         SEL_SUM:  res_o = sum_x;
         SEL_LESS: res_o = less_i;
         default:  res_o = 1'b0;
      endcase
   end

   assign carry_o = cy_x;
   assign sum_o   = sum_x;
   assign a_eff_o = a_x;
   assign b_eff_o = b_x;
endmodule

// File: rtl/bsalu_flags.sv
module bsalu_flags
   import bsalu_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] result_i,
   input  sel_e             sel_i,
   input  logic             c_top_in_i,
   input  logic             c_top_out_i,
   input  logic             sum_top_i,
   input  logic             a_top_i,
   input  logic             b_top_i,
   output logic             set_o,
   output logic             zero_o,
   output logic             ovf_o,
   output logic             carry_o
);
   logic raw_ovf, arith;

   assign raw_ovf = c_top_in_i ^ c_top_out_i;
   assign arith   = (sel_i == SEL_SUM);
   assign set_o   = sum_top_i ^ raw_ovf;
   assign zero_o  = ~(|result_i);
   assign ovf_o   = arith & raw_ovf;
   assign carry_o = arith & c_top_out_i;

   always_comb begin
      if (ovf_o) begin
         AST_NO_OVERFLOW: assert (a_top_i == b_top_i)
            else $error("overflow with operands of opposite sign"); // R11
         AST_OVF_SIGN: assert (sum_top_i != a_top_i)
            else $error("overflow but sign of result matches operand"); // R7
      end
   end
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
   import bsalu_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [3:0]       op_i,
   output logic [WIDTH-1:0] result_o,
   output logic             carry_o,
   output logic             overflow_o,
   output logic             zero_o
);
   localparam int unsigned MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("bitslice_alu needs WIDTH of at least 2");
   end

   opcode_t          opc;
   logic [WIDTH:0]   cy;
   logic [WIDTH-1:0] sum_v, a_eff, b_eff, res_v;
   logic             set_bit, ovf_w, cout_w, zero_w;

   assign opc   = opcode_t'(op_i);
   assign cy[0] = opc.neg_b;

   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      logic less_w;
      if (i == 0) begin : g_lsb
         assign less_w = set_bit;
      end else begin : g_upper
         assign less_w = 1'b0;
      end
      bsalu_cell u_cell (
         .a_i     (a_i[i]),
         .b_i     (b_i[i]),
         .inv_a_i (opc.inv_a),
         .neg_b_i (opc.neg_b),
         .sel_i   (opc.sel),
         .carry_i (cy[i]),
         .less_i  (less_w),
         .res_o   (res_v[i]),
         .carry_o (cy[i+1]),
         .sum_o   (sum_v[i]),
         .a_eff_o (a_eff[i]),
         .b_eff_o (b_eff[i])
      );
   end

   bsalu_flags #(.WIDTH(WIDTH)) u_flags (
      .result_i    (res_v),
      .sel_i       (opc.sel),
      .c_top_in_i  (cy[MSB]),
      .c_top_out_i (cy[WIDTH]),
      .sum_top_i   (sum_v[MSB]),
      .a_top_i     (a_eff[MSB]),
      .b_top_i     (b_eff[MSB]),
      .set_o       (set_bit),
      .zero_o      (zero_w),
      .ovf_o       (ovf_w),
      .carry_o     (cout_w)
   );

   assign result_o   = res_v;
   assign carry_o    = cout_w;
   assign overflow_o = ovf_w;
   assign zero_o     = zero_w;

   always_comb begin
      if (op_i == OPC_SLT) begin
         AST_SLT_VALUE: assert (result_o[0] == ($signed(a_i) < $signed(b_i)))
            else $error("less-than bit wrong"); // R5
         AST_SLT_UPPER: assert (result_o[MSB:1] == '0)
            else $error("less-than upper bits not zero"); // R5
      end
      if (op_i == OPC_SUB) begin
         AST_SUB_CARRY: assert (carry_o == (a_i >= b_i))
            else $error("subtract carry does not match borrow"); // R9
      end
      if (op_i == OPC_AND || op_i == OPC_OR || op_i == OPC_NOR || op_i == OPC_SLT) begin
         AST_LOGIC_FLAGS: assert (!overflow_o && !carry_o)
            else $error("flag raised by non-arithmetic operation"); // R8
      end
   end
endmodule

// File: tb/bitslice_alu_bench.sv
module bitslice_alu_bench;
   localparam int W = 32;
   localparam int WATCHDOG = 150000;

   typedef struct {
      logic [W-1:0] res;
      logic         c;
      logic         v;
      logic         z;
      string        tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [W-1:0] a = '0, b = '0;
   logic [3:0]   op = 4'b0000;
   logic [W-1:0] result;
   logic carry, overflow, zero;

   int checks = 0, fails = 0;
   bit done = 0;
   exp_t sb[$];

   always #4 clk = ~clk;

   bitslice_alu #(.WIDTH(W)) u_bitslice_alu (
      .a_i(a), .b_i(b), .op_i(op),
      .result_o(result), .carry_o(carry), .overflow_o(overflow), .zero_o(zero)
   );

   function automatic exp_t model(logic [W-1:0] x, logic [W-1:0] y, logic [3:0] o);
      exp_t e;
      logic [W:0] s;
      e.c = 0; e.v = 0;
      case (o)
         4'b0000: begin e.res = x & y;    e.tag = "R1"; end
         4'b0001: begin e.res = x | y;    e.tag = "R2"; end
         4'b1100: begin e.res = ~(x | y); e.tag = "R6"; end
         4'b0010: begin
            s = {1'b0, x} + {1'b0, y};
            e.res = s[W-1:0]; e.c = s[W];
            e.v = (x[W-1] == y[W-1]) && (e.res[W-1] != x[W-1]);
            e.tag = "R3";
         end
         4'b0110: begin
            s = {1'b0, x} + {1'b0, ~y} + 1;
            e.res = s[W-1:0]; e.c = s[W];
            e.v = (x[W-1] != y[W-1]) && (e.res[W-1] != x[W-1]);
            e.tag = "R4";
         end
         default: begin
            e.res = {{(W-1){1'b0}}, ($signed(x) < $signed(y))};
            e.tag = "R5";
         end
      endcase
      e.z = (e.res == '0);
      return e;
   endfunction

   task automatic drive(logic [W-1:0] x, logic [W-1:0] y, logic [3:0] o);
      @(posedge clk);
      #1;
      a = x; b = y; op = o;
      sb.push_back(model(x, y, o));
   endtask

   always @(negedge clk) begin
      if (!rst && sb.size() > 0) begin
         exp_t e;
         bit bad;
         e = sb.pop_front();
         bad = 0;
         checks++;
         if (result !== e.res) begin
            $display("FAIL %s result actual=%h expected=%h", e.tag, result, e.res); bad = 1;
         end
         if (carry !== e.c) begin
            $display("FAIL R9 carry actual=%b expected=%b", carry, e.c); bad = 1;
         end
         if (overflow !== e.v) begin
            $display("FAIL R7/R8/R11 overflow actual=%b expected=%b", overflow, e.v); bad = 1;
         end
         if (zero !== e.z) begin
            $display("FAIL R10 zero actual=%b expected=%b", zero, e.z); bad = 1;
         end
         if (bad) fails++;
      end
   end

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog (all requirements) actual=hung expected=done");
         finish_run();
      end
   end

   localparam logic [3:0] OPS [6] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};

   initial begin
      repeat (3) @(posedge clk);
      rst = 0;
      // initial state: zero operands under AND, R10 zero flag high
      drive('0, '0, 4'b0000);
      // R1, R2, R6 on fixed patterns
      drive(32'hF0F0_A5A5, 32'hFF00_0F0F, 4'b0000);
      drive(32'hF0F0_A5A5, 32'hFF00_0F0F, 4'b0001);
      drive(32'hF0F0_A5A5, 32'hFF00_0F0F, 4'b1100);
      drive('1, '1, 4'b1100);               // R6 and R10: NOR gives zero
      drive('1, '1, 4'b0001);               // R8: no flags for OR of all ones
      // R3, R7, R9 add corners
      drive(32'h7FFF_FFFF, 32'h0000_0001, 4'b0010); // positive overflow
      drive(32'h8000_0000, 32'h8000_0000, 4'b0010); // negative overflow, carry, zero
      drive(32'hFFFF_FFFF, 32'h0000_0001, 4'b0010); // carry, zero, no overflow
      drive(32'h7FFF_FFFF, 32'h8000_0000, 4'b0010); // R11 opposite signs
      drive(32'h8000_0001, 32'h7FFF_FFFF, 4'b0010); // R11 opposite signs with carry
      // R4 subtract corners
      drive(32'h8000_0000, 32'h0000_0001, 4'b0110); // overflow
      drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0110); // overflow other way
      drive(32'h0000_0005, 32'h0000_0005, 4'b0110); // zero, carry 1
      drive(32'h0000_0003, 32'h0000_0005, 4'b0110); // borrow, carry 0
      // R5 less-than including overflowing differences
      drive(32'h8000_0000, 32'h0000_0001, 4'b0111);
      drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111);
      drive(32'hFFFF_FFFF, 32'h0000_0000, 4'b0111);
      drive(32'h0000_0004, 32'h0000_0004, 4'b0111);
      drive(32'h0000_0002, 32'h0000_0009, 4'b0111);
      // random sweep of every operation
      for (int n = 0; n < 400; n++) begin
         for (int k = 0; k < 6; k++) begin
            logic [W-1:0] x, y;
            x = $urandom; y = $urandom;
            if (n % 4 == 0) y = {x[W-1], y[W-2:0]};
            if (n % 7 == 0) y = x;
            drive(x, y, OPS[k]);
         end
      end
      @(posedge clk);
      @(posedge clk);
      done = 1;
      finish_run();
   end
endmodule